// File: doc/BRIEF.md
# Register Producer Map with Rename History

This block keeps, for every architectural register, the identity of the function unit that will produce the register's newest value. A register with no pending producer maps to the register file. Each row of the map is a one-hot field over the function units. The issue port writes a row through a one-hot row decoder. The lookup port turns the selected row back into a binary unit id with a one-hot-to-binary encoder.

A newer instruction can name a register whose producer is still pending. In that case the older producer is displaced: it becomes nameless and must not write its result back. Consumers obtain its value by forwarding from that unit's output latch instead. The displaced mapping is not thrown away. It is pushed onto a small per-register stack. If the newer producer is rolled back because a dependent faulted, the top stack entry returns as the named owner and its nameless flag drops, so that unit writes back normally. A nameless unit whose consumers are all past their exception point is discarded, and it leaves the map. When the history stack of the target register is full, the issue port signals a stall and nothing changes.

Top module: `regmap_history`

## Requirements
- R1: After reset, every register maps to the register file (`lookupHit` low for every `lookupReg`), and no unit is nameless.
- R2: An accepted issue of unit F to register D, where D has no pending producer, makes lookup of D return hit with `lookupFu` = F from the next cycle. It sets no nameless flag.
- R3: An accepted issue to register D, where D currently maps to unit G, makes lookup of D return the new unit. It also sets `nameless[G]` from the next cycle. Bit f of `nameless` belongs to unit id f.
- R4: A retire pulse on unit F removes F from the map. A register owned by F maps to the register file from the next cycle, and `nameless[F]` is low.
- R5: A discard pulse on a nameless unit clears its nameless flag from the next cycle. Lookup of every register still returns the same result as before.
- R6: The history stack holds `HIST_DEPTH` (default 2) older producers per register. An issue to a register that has a pending producer and a full stack raises `issueStall` in the same cycle and changes no lookup result and no nameless flag.
- R7: A rollback pulse on the current producer of register D pops the top stack entry of D. That older unit becomes the owner seen by lookup from the next cycle, and its nameless flag is cleared.
- R8: A rollback of the current producer of register D whose stack is empty makes D map to the register file.
- R9: An issue presented in a cycle with any rollback bit set raises `issueStall` and is not performed.
- R10: A rollback, retire or discard of a unit held inside a stack removes that entry. A later pop reaching that slot leaves the register mapped to the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request strobe |
| issueReg | input | 3 | Destination register of the issue |
| issueFu | input | 2 | Unit id taking the destination |
| issueStall | output | 1 | Issue refused this cycle (full stack or rollback) |
| lookupReg | input | 3 | Source register to look up |
| lookupHit | output | 1 | Register has a pending producer |
| lookupFu | output | 2 | Id of that producer when hit |
| nameless | output | 4 | Per unit: result must not be written back |
| retire | input | 4 | Per unit: result written back, leave the map |
| discard | input | 4 | Per unit: nameless result dropped, leave the map |
| rollback | input | 4 | Per unit: instruction squashed |

## Verification
A corrupted row shows at the lookup port in the cycle after the bad update, as a wrong or missing unit id. A stack with a wrong count or a stale entry stays hidden until a rollback pops it. The wrong owner then appears at lookup one cycle after that rollback, together with a nameless flag that stays set or clears at the wrong unit. The bench sweeps lookup over all registers after every step and compares all nameless flags, so a fault shows within one cycle of the step that exposes it. Rollback chains are run to the bottom of the stack so that stale history is exposed.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  parameter int NUM_REGS   = 8;
  parameter int NUM_FUS    = 4;
  parameter int HIST_DEPTH = 2;
  localparam int REG_W = $clog2(NUM_REGS);
  localparam int FU_W  = $clog2(NUM_FUS);
  localparam int CNT_W = $clog2(HIST_DEPTH + 1);

  typedef logic [NUM_FUS-1:0] fuVec_t;

  // strobes from control to the storage datapath
  typedef struct packed {
    logic                issueEn;
    logic [NUM_REGS-1:0] issueSel;
    fuVec_t              issueFu;
    fuVec_t              freeMask;  // units leaving the map this cycle
    fuVec_t              rollMask;  // units squashed this cycle
  } strobes_t;
endpackage

// File: rtl/regmap_store.sv
module regmap_store
  import regmap_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  strobes_t strb,
  output fuVec_t   rows [NUM_REGS],
  output logic [NUM_REGS-1:0] histFull,
  output fuVec_t   restored,
  output fuVec_t   ownerMask
);
  fuVec_t rowQ  [NUM_REGS];
  fuVec_t histQ [NUM_REGS][HIST_DEPTH];
  logic [CNT_W-1:0] cntQ [NUM_REGS];
  fuVec_t restoredPer [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    fuVec_t rowKept, topEntry;
    logic   popHere, pushHere, issueHere;

    always_comb begin
      rowKept   = rowQ[r] & ~strb.freeMask;
      issueHere = strb.issueEn && strb.issueSel[r];
      pushHere  = issueHere && (|rowKept);
      popHere   = |(rowQ[r] & strb.rollMask);
      topEntry  = '0;
      for (int d = 0; d < HIST_DEPTH; d++)
        if (int'(cntQ[r]) == d + 1) topEntry = histQ[r][d] & ~strb.freeMask;
      restoredPer[r] = popHere ? topEntry : '0;
      histFull[r]    = (int'(cntQ[r]) == HIST_DEPTH);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rowQ[r] <= '0;
        cntQ[r] <= '0;
        for (int d = 0; d < HIST_DEPTH; d++) histQ[r][d] <= '0;
      end else begin
        for (int d = 0; d < HIST_DEPTH; d++) begin
          histQ[r][d] <= histQ[r][d] & ~strb.freeMask;
          if (pushHere && int'(cntQ[r]) == d) histQ[r][d] <= rowKept;
        end
        if (issueHere) begin
          rowQ[r] <= strb.issueFu;
          if (pushHere) cntQ[r] <= cntQ[r] + 1'b1;
        end else if (popHere) begin
          rowQ[r] <= topEntry;
          if (cntQ[r] != '0) cntQ[r] <= cntQ[r] - 1'b1;
        end else begin
          rowQ[r] <= rowKept;
        end
      end
    end

    assign rows[r] = rowQ[r];

    p_row_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(rowQ[r]));
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
      int'(cntQ[r]) <= HIST_DEPTH);
  end

  always_comb begin
    restored  = '0;
    ownerMask = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      restored  = restored | restoredPer[r];
      ownerMask = ownerMask | rowQ[r];
    end
  end

  // a unit that left the map does not own a register in the next cycle
  p_freed_gone_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.freeMask) |=> ((ownerMask &
      $past(strb.freeMask & ~(strb.issueEn ? strb.issueFu : '0))) == '0));
endmodule

// File: rtl/regmap_ctrl.sv
module regmap_ctrl
  import regmap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic [REG_W-1:0] issueReg,
  input  logic [FU_W-1:0]  issueFu,
  input  logic [REG_W-1:0] lookupReg,
  input  fuVec_t           retire,
  input  fuVec_t           discard,
  input  fuVec_t           rollback,
  input  fuVec_t           rows [NUM_REGS],
  input  logic [NUM_REGS-1:0] histFull,
  input  fuVec_t           restored,
  input  fuVec_t           ownerMask,
  output strobes_t         strb,
  output logic             issueStall,
  output logic             lookupHit,
  output logic [FU_W-1:0]  lookupFu,
  output fuVec_t           nameless
);
  fuVec_t namelessQ, selRow, issueOh, lookupRow;

  always_comb begin
    strb.freeMask = retire | discard | rollback;
    strb.rollMask = rollback;
    selRow        = rows[issueReg] & ~strb.freeMask;
    issueStall    = issueValid && ((|rollback) || ((|selRow) && histFull[issueReg]));
    strb.issueEn  = issueValid && !issueStall;
    issueOh       = '0;
    issueOh[issueFu] = 1'b1;
    strb.issueFu  = issueOh;
    strb.issueSel = '0;
    strb.issueSel[issueReg] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) namelessQ <= '0;
    else namelessQ <= (namelessQ | (strb.issueEn ? selRow : '0))
                      & ~strb.freeMask & ~restored
                      & ~(strb.issueEn ? issueOh : '0);
  end
  assign nameless = namelessQ;

  // one-hot to binary lookup encoder
  always_comb begin
    lookupRow = rows[lookupReg];
    lookupHit = |lookupRow;
    lookupFu  = '0;
    for (int f = 0; f < NUM_FUS; f++)
      if (lookupRow[f]) lookupFu = lookupFu | FU_W'(f);
  end

  p_nameless_not_owner_r3: assert property (@(posedge clk) disable iff (!rstN)
    (namelessQ & ownerMask) == '0);
  p_restore_named_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|restored) |=> (($past(restored) & namelessQ) == '0));
endmodule

// File: rtl/regmap_history.sv
module regmap_history
  import regmap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic [REG_W-1:0] issueReg,
  input  logic [FU_W-1:0]  issueFu,
  output logic             issueStall,
  input  logic [REG_W-1:0] lookupReg,
  output logic             lookupHit,
  output logic [FU_W-1:0]  lookupFu,
  output logic [NUM_FUS-1:0] nameless,
  input  logic [NUM_FUS-1:0] retire,
  input  logic [NUM_FUS-1:0] discard,
  input  logic [NUM_FUS-1:0] rollback
);
  strobes_t strb;
  fuVec_t rows [NUM_REGS];
  logic [NUM_REGS-1:0] histFull;
  fuVec_t restored, ownerMask;

  regmap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReg(issueReg),
    .issueFu(issueFu), .lookupReg(lookupReg), .retire(retire),
    .discard(discard), .rollback(rollback), .rows(rows), .histFull(histFull),
    .restored(restored), .ownerMask(ownerMask), .strb(strb),
    .issueStall(issueStall), .lookupHit(lookupHit), .lookupFu(lookupFu),
    .nameless(nameless)
  );

  regmap_store u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .rows(rows), .histFull(histFull),
    .restored(restored), .ownerMask(ownerMask)
  );
endmodule

// File: tb/regmap_history_tb.sv
module regmap_history_tb;
  localparam int CLK_PERIOD = 40;
  localparam int NR = 8, NF = 4, HD = 2;

  logic clk = 0, rstN = 0;
  logic issueValid = 0;
  logic [2:0] issueReg = 0, lookupReg = 0;
  logic [1:0] issueFu = 0, lookupFu;
  logic issueStall, lookupHit;
  logic [3:0] nameless, retire = 0, discard = 0, rollback = 0;

  int checks = 0, failures = 0;
  bit done = 0;
  int curM [NR];
  int histM [NR][HD];
  int cntM [NR];
  bit nlM [NF];

  always #(CLK_PERIOD/2) clk = ~clk;

  regmap_history u_dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit modelStall(bit iv, int r, bit [3:0] rb);
    if (!iv) return 0;
    if (rb != 0) return 1;
    return (curM[r] >= 0) && (cntM[r] == HD);
  endfunction

  function automatic void modelRemove(int f);
    for (int r = 0; r < NR; r++) begin
      if (curM[r] == f) curM[r] = -1;
      for (int d = 0; d < HD; d++) if (histM[r][d] == f) histM[r][d] = -1;
    end
    nlM[f] = 0;
  endfunction

  function automatic void modelRollback(int f);
    for (int r = 0; r < NR; r++) begin
      if (curM[r] == f) begin
        if (cntM[r] > 0) begin
          cntM[r]--;
          curM[r] = histM[r][cntM[r]];
          if (curM[r] >= 0) nlM[curM[r]] = 0;
        end else curM[r] = -1;
      end
      for (int d = 0; d < HD; d++) if (histM[r][d] == f) histM[r][d] = -1;
    end
    nlM[f] = 0;
  endfunction

  function automatic void modelIssue(int r, int f);
    if (curM[r] >= 0) begin
      histM[r][cntM[r]] = curM[r];
      cntM[r]++;
      nlM[curM[r]] = 1;
    end
    curM[r] = f;
    nlM[f] = 0;
  endfunction

  function automatic bit fuBusy(int f);
    for (int r = 0; r < NR; r++) begin
      if (curM[r] == f) return 1;
      for (int d = 0; d < cntM[r]; d++) if (histM[r][d] == f) return 1;
    end
    return 0;
  endfunction

  task automatic sweep(input string tag);
    for (int r = 0; r < NR; r++) begin
      lookupReg = 3'(r);
      #1;
      check({tag, " hit"}, int'(lookupHit), int'(curM[r] >= 0));
      if (curM[r] >= 0) check({tag, " fu"}, int'(lookupFu), curM[r]);
    end
    for (int f = 0; f < NF; f++) check({tag, " nameless"}, int'(nameless[f]), int'(nlM[f]));
  endtask

  task automatic step(input bit iv, input int r, input int f,
                      input bit [3:0] ret, input bit [3:0] dis, input bit [3:0] rb,
                      input string tag);
    bit st;
    @(negedge clk);
    issueValid = iv; issueReg = 3'(r); issueFu = 2'(f);
    retire = ret; discard = dis; rollback = rb;
    #1;
    st = modelStall(iv, r, rb);
    check({tag, " stall"}, int'(issueStall), int'(st));
    for (int u = 0; u < NF; u++) begin
      if (ret[u] || dis[u]) modelRemove(u);
      if (rb[u]) modelRollback(u);
    end
    if (iv && !st) modelIssue(r, f);
    @(posedge clk);
    #1;
    issueValid = 0; retire = 0; discard = 0; rollback = 0;
    sweep(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) begin
      curM[r] = -1; cntM[r] = 0;
      for (int d = 0; d < HD; d++) histM[r][d] = -1;
    end
    for (int f = 0; f < NF; f++) nlM[f] = 0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    sweep("R1 reset");

    step(1, 3, 0, 0, 0, 0, "R2 first issue");
    step(1, 3, 1, 0, 0, 0, "R3 overwrite");
    step(1, 3, 2, 0, 0, 0, "R3 overwrite again");
    step(1, 3, 3, 0, 0, 0, "R6 full stack");
    step(0, 0, 0, 0, 0, 4'b0100, "R7 rollback newest");
    step(0, 0, 0, 0, 0, 4'b0010, "R7 rollback next");
    step(0, 0, 0, 0, 0, 4'b0001, "R8 rollback empty");
    step(1, 5, 0, 0, 0, 0, "R2 issue r5");
    step(1, 5, 1, 0, 0, 0, "R3 overwrite r5");
    step(0, 0, 0, 0, 4'b0001, 0, "R5 discard");
    step(0, 0, 0, 4'b0010, 0, 0, "R4 retire");
    step(1, 2, 2, 0, 0, 4'b1000, "R9 issue during rollback");
    step(1, 6, 0, 0, 0, 0, "R10 setup");
    step(1, 6, 1, 0, 0, 0, "R10 setup");
    step(1, 6, 2, 0, 0, 0, "R10 setup");
    step(0, 0, 0, 0, 0, 4'b0010, "R10 squash middle");
    step(0, 0, 0, 0, 0, 4'b0100, "R10 pop hole");
    step(0, 0, 0, 0, 0, 4'b0001, "R10 cleanup");

    for (int n = 0; n < 800; n++) begin
      int kind = $urandom_range(0, 5);
      int r = $urandom_range(0, NR-1);
      int f = $urandom_range(0, NF-1);
      bit [3:0] m = 4'(1 << f);
      if (kind <= 1) begin
        if (!fuBusy(f)) step(1, r, f, 0, 0, 0, "RND R3 issue");
        else step(0, 0, 0, 0, 0, 0, "RND idle");
      end else if (kind == 2) begin
        if (fuBusy(f) && !nlM[f]) step(0, 0, 0, m, 0, 0, "RND R4 retire");
        else step(0, 0, 0, 0, 0, 0, "RND idle");
      end else if (kind == 3) begin
        if (nlM[f]) step(0, 0, 0, 0, m, 0, "RND R5 discard");
        else step(0, 0, 0, 0, 0, 0, "RND idle");
      end else if (kind == 4) begin
        if (fuBusy(f)) step(0, 0, 0, 0, 0, m, "RND R7 rollback");
        else step(0, 0, 0, 0, 0, 0, "RND idle");
      end else begin
        int g = $urandom_range(0, NF-1);
        step(!fuBusy(g), r, g, 0, 0, 0, "RND R6 issue");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule